// File: doc/BRIEF.md
# Deferred-Allocation Reorder Structure

This block holds the window of in-flight instructions for an out-of-order core model. An instruction does not receive an entry when it is decoded. It waits outside the block until every source operand is resolved. Only then does the dispatch port allocate one of a few execution entries and one slot in a circular rename ring. Entries hand their instructions to the execution side strictly in program order. An entry returns to the free pool in the cycle its completion arrives, so the costly entry storage is tied up only from operand readiness to completion, never until retirement.

The completion port writes the result straight into the rename ring slot of that instruction. The ring retires at most one instruction per cycle from its oldest end, in program order. Each retirement drives the commit port with the destination register index and the value, and the architectural register file beside the block captures it. A flush discards every instruction that has not yet retired. The rename ring depth must be a power of two.

Top module: `late_alloc_rob`

## Requirements
- R1: A dispatch request is taken in a cycle only when disp_valid, disp_ops_ready and disp_ready are all high. A request with disp_ops_ready low takes no entry and no rename slot, and it never appears on the issue port.
- R2: Each accepted instruction occupies the lowest-numbered free entry, and that entry number appears on issue_tag when the instruction issues.
- R3: issue_valid is high whenever some accepted instruction has not yet issued. The issue port always presents the oldest such instruction with its dispatched operand on issue_opnd. At most one instruction issues per cycle, when issue_ready is high.
- R4: A completion whose cmpl_tag names an entry holding an issued instruction stores cmpl_value in that instruction's rename slot. It frees the entry for dispatch from the next cycle, even while the instruction remains uncommitted.
- R5: A completion whose tag names a free entry, or an entry whose instruction has not issued, has no effect.
- R6: disp_ready is low while all N_ENT (default 8) entries are occupied.
- R7: disp_ready is low while N_RS (default 16) instructions are uncommitted, even when entries are free.
- R8: commit_valid is high in exactly the cycles in which the oldest uncommitted instruction has completed. It presents that instruction's destination and result, and at most one instruction retires per cycle, in program order.
- R9: In a cycle with flush high, disp_ready, issue_valid and commit_valid are low and any completion is ignored. From the next cycle, no uncommitted instruction remains and all entries are free.
- R10: After a run drains, the register state built from the commit port equals a sequential execution of all dispatched instructions that no flush discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard all uncommitted instructions |
| disp_valid | input | 1 | Dispatch request present |
| disp_ops_ready | input | 1 | All source operands of the request are resolved |
| disp_dest | input | AR_W | Destination architectural register index |
| disp_opnd | input | DW | Resolved source operand value |
| disp_ready | output | 1 | An entry and a rename slot are available |
| issue_valid | output | 1 | Oldest unissued instruction offered to execution |
| issue_ready | input | 1 | Execution side accepts the offered instruction |
| issue_tag | output | ENT_W | Entry number of the offered instruction |
| issue_opnd | output | DW | Operand of the offered instruction |
| cmpl_valid | input | 1 | Completion present |
| cmpl_tag | input | ENT_W | Entry number of the completing instruction |
| cmpl_value | input | DW | Result value |
| commit_valid | output | 1 | Register file write this cycle |
| commit_dest | output | AR_W | Register index written |
| commit_value | output | DW | Value written |

## Verification
Directed phases come first. They feed requests with unresolved operands, which should leave the issue port idle. They stall issue until all entries fill, which separates the entry limit from the ring limit. They send a completion to an entry that has not issued. They hold back the oldest completion while younger ones finish, which shows entries freeing before retirement and the ring then filling to its own limit. A constrained-random stream follows, with random readiness, issue backpressure, out-of-order completion latencies and occasional flushes. Every cycle is compared against a bench model of entry occupancy, issue order and retirement. The final register values are compared against a sequential replay of the surviving instruction log, which shows whether flushes discarded exactly the uncommitted work.

// File: rtl/lar_pkg.sv
package lar_pkg;

  // Index of the lowest set bit among the first n bits of m (0 when none).
  function automatic int unsigned lowest_one(input logic [63:0] m, input int unsigned n);
    int unsigned r;
    r = 0;
    for (int i = 63; i >= 0; i--) begin
      if (i < int'(n) && m[i]) r = i;
    end
    return r;
  endfunction

  // Occupancy of a ring from two wrap-bit pointers.
  function automatic int unsigned ring_used(input int unsigned head, input int unsigned tail,
                                            input int unsigned pw);
    int unsigned mask;
    mask = (1 << pw) - 1;
    return (tail - head) & mask;
  endfunction

endpackage

// File: rtl/lar_entry_pool.sv
module lar_entry_pool
  import lar_pkg::*;
#(
  parameter int unsigned N_ENT = 8,
  parameter int unsigned RS_W  = 4,
  parameter int unsigned DW    = 16,
  localparam int unsigned ENT_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             alloc_en,
  input  logic [RS_W-1:0]  alloc_rslot,
  input  logic [DW-1:0]    alloc_opnd,
  output logic             any_free,
  input  logic [RS_W-1:0]  iss_rslot,
  output logic             iss_hit,
  output logic [ENT_W-1:0] iss_idx,
  output logic [DW-1:0]    iss_opnd,
  input  logic             iss_fire,
  input  logic             cmp_en,
  input  logic [ENT_W-1:0] cmp_idx,
  output logic             cmp_ok,
  output logic [RS_W-1:0]  cmp_rslot
);

  logic [N_ENT-1:0] vld;
  logic [N_ENT-1:0] isd;
  logic [RS_W-1:0]  rsl [N_ENT];
  logic [DW-1:0]    opd [N_ENT];
  logic [ENT_W-1:0] alloc_idx;

  assign any_free  = ~&vld;
  assign alloc_idx = ENT_W'(lowest_one(64'(~vld), N_ENT));

  // Lookup of the entry holding the ring slot that is next to issue.
  always_comb begin
    iss_hit = 1'b0;
    iss_idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (vld[i] && !isd[i] && rsl[i] == iss_rslot) begin
        iss_hit = 1'b1;
        iss_idx = ENT_W'(i);
      end
    end
  end

  assign iss_opnd  = opd[iss_idx];
  assign cmp_ok    = cmp_en && vld[cmp_idx] && isd[cmp_idx];
  assign cmp_rslot = rsl[cmp_idx];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      vld <= '0;
      isd <= '0;
    end else begin
      if (cmp_ok) vld[cmp_idx] <= 1'b0;
      if (iss_fire) isd[iss_idx] <= 1'b1;
      if (alloc_en) begin
        vld[alloc_idx] <= 1'b1;
        isd[alloc_idx] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_en) begin
      rsl[alloc_idx] <= alloc_rslot;
      opd[alloc_idx] <= alloc_opnd;
    end
  end

endmodule

// File: rtl/lar_rename_ring.sv
module lar_rename_ring
  import lar_pkg::*;
#(
  parameter int unsigned N_RS = 16,
  parameter int unsigned AR_W = 3,
  parameter int unsigned DW   = 16,
  localparam int unsigned RS_W = $clog2(N_RS),
  localparam int unsigned PW   = RS_W + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            alloc_en,
  input  logic [AR_W-1:0] alloc_dest,
  output logic [RS_W-1:0] tail_slot,
  output logic            full,
  output logic [RS_W-1:0] iss_slot,
  output logic            iss_pend,
  input  logic            iss_fire,
  input  logic            wr_en,
  input  logic [RS_W-1:0] wr_slot,
  input  logic [DW-1:0]   wr_val,
  output logic            cm_valid,
  output logic [AR_W-1:0] cm_dest,
  output logic [DW-1:0]   cm_val
);

  logic [PW-1:0]   head, iss, tail;
  logic [N_RS-1:0] done;
  logic [AR_W-1:0] dst [N_RS];
  logic [DW-1:0]   val [N_RS];
  logic [RS_W-1:0] head_slot;

  assign head_slot = head[RS_W-1:0];
  assign tail_slot = tail[RS_W-1:0];
  assign iss_slot  = iss[RS_W-1:0];
  assign full      = ring_used(head, tail, PW) == N_RS;
  assign iss_pend  = iss != tail;
  assign cm_valid  = (head != tail) && done[head_slot] && !flush;
  assign cm_dest   = dst[head_slot];
  assign cm_val    = val[head_slot];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      iss  <= '0;
      tail <= '0;
      done <= '0;
    end else if (flush) begin
      iss  <= head;
      tail <= head;
      done <= '0;
    end else begin
      if (cm_valid) begin
        head            <= head + 1'b1;
        done[head_slot] <= 1'b0;
      end
      if (iss_fire) iss <= iss + 1'b1;
      if (wr_en) done[wr_slot] <= 1'b1;
      if (alloc_en) begin
        tail            <= tail + 1'b1;
        done[tail_slot] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_en) dst[tail_slot] <= alloc_dest;
    if (wr_en) val[wr_slot] <= wr_val;
  end

endmodule

// File: rtl/late_alloc_rob.sv
module late_alloc_rob #(
  parameter int unsigned N_ENT  = 8,
  parameter int unsigned N_RS   = 16,
  parameter int unsigned N_AREG = 8,
  parameter int unsigned DW     = 16,
  localparam int unsigned ENT_W = $clog2(N_ENT),
  localparam int unsigned RS_W  = $clog2(N_RS),
  localparam int unsigned AR_W  = $clog2(N_AREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             disp_valid,
  input  logic             disp_ops_ready,
  input  logic [AR_W-1:0]  disp_dest,
  input  logic [DW-1:0]    disp_opnd,
  output logic             disp_ready,
  output logic             issue_valid,
  input  logic             issue_ready,
  output logic [ENT_W-1:0] issue_tag,
  output logic [DW-1:0]    issue_opnd,
  input  logic             cmpl_valid,
  input  logic [ENT_W-1:0] cmpl_tag,
  input  logic [DW-1:0]    cmpl_value,
  output logic             commit_valid,
  output logic [AR_W-1:0]  commit_dest,
  output logic [DW-1:0]    commit_value
);

  // Named internal events, also observed by the bound checker.
  logic            disp_fire;
  logic            issue_fire;
  logic            release_ev;
  logic            commit_fire;
  logic            ent_free;
  logic            ring_full;
  logic            iss_hit;
  logic            iss_pend;
  logic [RS_W-1:0] tail_slot;
  logic [RS_W-1:0] iss_slot;
  logic [RS_W-1:0] rel_slot;

  assign disp_ready  = ent_free && !ring_full && !flush;
  assign disp_fire   = disp_valid && disp_ops_ready && disp_ready;
  assign issue_valid = iss_pend && iss_hit && !flush;
  assign issue_fire  = issue_valid && issue_ready;
  assign commit_fire = commit_valid;

  lar_entry_pool #(.N_ENT(N_ENT), .RS_W(RS_W), .DW(DW)) pool_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .alloc_en   (disp_fire),
    .alloc_rslot(tail_slot),
    .alloc_opnd (disp_opnd),
    .any_free   (ent_free),
    .iss_rslot  (iss_slot),
    .iss_hit    (iss_hit),
    .iss_idx    (issue_tag),
    .iss_opnd   (issue_opnd),
    .iss_fire   (issue_fire),
    .cmp_en     (cmpl_valid && !flush),
    .cmp_idx    (cmpl_tag),
    .cmp_ok     (release_ev),
    .cmp_rslot  (rel_slot)
  );

  lar_rename_ring #(.N_RS(N_RS), .AR_W(AR_W), .DW(DW)) ring_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .alloc_en  (disp_fire),
    .alloc_dest(disp_dest),
    .tail_slot (tail_slot),
    .full      (ring_full),
    .iss_slot  (iss_slot),
    .iss_pend  (iss_pend),
    .iss_fire  (issue_fire),
    .wr_en     (release_ev),
    .wr_slot   (rel_slot),
    .wr_val    (cmpl_value),
    .cm_valid  (commit_valid),
    .cm_dest   (commit_dest),
    .cm_val    (commit_value)
  );

endmodule

// File: rtl/lar_checker.sv
module lar_checker #(
  parameter int unsigned N_ENT = 8,
  parameter int unsigned N_RS  = 16
) (
  input logic clk,
  input logic rst_n,
  input logic flush,
  input logic disp_fire,
  input logic issue_fire,
  input logic release_ev,
  input logic commit_fire,
  input logic disp_ready,
  input logic issue_valid,
  input logic commit_valid
);

  logic [7:0] ent_cnt, rs_cnt, exec_cnt, done_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      ent_cnt  <= '0;
      rs_cnt   <= '0;
      exec_cnt <= '0;
      done_cnt <= '0;
    end else begin
      ent_cnt  <= ent_cnt + 8'(disp_fire) - 8'(release_ev);
      rs_cnt   <= rs_cnt + 8'(disp_fire) - 8'(commit_fire);
      exec_cnt <= exec_cnt + 8'(issue_fire) - 8'(release_ev);
      done_cnt <= done_cnt + 8'(release_ev) - 8'(commit_fire);
    end
  end

  a_r6_entry_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_cnt == 8'(N_ENT)) |-> !disp_ready);

  a_r7_ring_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_cnt == 8'(N_RS)) |-> !disp_ready);

  a_r4_release_needs_issue: assert property (@(posedge clk) disable iff (!rst_n)
    release_ev |-> (exec_cnt != 8'd0));

  a_r8_commit_needs_result: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> (done_cnt != 8'd0));

  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!issue_valid && !commit_valid));

endmodule

bind late_alloc_rob lar_checker #(.N_ENT(N_ENT), .N_RS(N_RS)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .flush       (flush),
  .disp_fire   (disp_fire),
  .issue_fire  (issue_fire),
  .release_ev  (release_ev),
  .commit_fire (commit_fire),
  .disp_ready  (disp_ready),
  .issue_valid (issue_valid),
  .commit_valid(commit_valid)
);

// File: tb/late_alloc_rob_tb_top.sv
module late_alloc_rob_tb_top;

  localparam int NE = 8;
  localparam int NR = 16;
  localparam int NA = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flush = 1'b0;
  logic          disp_valid = 1'b0, disp_ops_ready = 1'b0;
  logic [2:0]    disp_dest = '0;
  logic [DW-1:0] disp_opnd = '0;
  logic          disp_ready;
  logic          issue_valid, issue_ready = 1'b0;
  logic [2:0]    issue_tag;
  logic [DW-1:0] issue_opnd;
  logic          cmpl_valid = 1'b0;
  logic [2:0]    cmpl_tag = '0;
  logic [DW-1:0] cmpl_value = '0;
  logic          commit_valid;
  logic [2:0]    commit_dest;
  logic [DW-1:0] commit_value;

  always #4 clk = ~clk;

  late_alloc_rob #(.N_ENT(NE), .N_RS(NR), .N_AREG(NA), .DW(DW)) dut_i (.*);

  int ncmp = 0, nmis = 0;

  // Bench model state
  int m_head = 0, m_iss = 0, m_tail = 0;
  logic [NE-1:0] m_ent = '0;
  logic [2:0]    m_dest [32];
  logic [DW-1:0] m_opnd [32];
  logic [2:0]    m_tag  [32];
  bit            m_done [32];
  logic [DW-1:0] m_val  [32];
  int            m_lg   [32];
  bit if_v [NE];
  int if_seq [NE];
  int if_dly [NE];
  logic [2:0]    lg_dest [8192];
  logic [DW-1:0] lg_opnd [8192];
  bit            lg_kill [8192];
  int lg_n = 0;
  logic [DW-1:0] arch [NA];

  // Knobs
  bit k_rand = 0, k_rflush = 0, k_flush = 0, k_disp = 0, k_ops = 0, k_iss = 0, k_cmp = 0, k_hold = 0;
  int k_bogus = -1;

  function automatic logic [DW-1:0] res_fn(input logic [DW-1:0] o, input logic [2:0] d);
    return o * 16'd5 + {13'd0, d} + 16'd3;
  endfunction

  function automatic int first_free(input logic [NE-1:0] m);
    for (int i = 0; i < NE; i++) if (!m[i]) return i;
    return 0;
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    ncmp++;
    if (act !== exp) begin
      nmis++;
      $display("FAIL %s act=%0h exp=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic cycle();
    bit fl, creal, exp_dr, exp_iv, exp_cv;
    int ctag, at;
    string rq;
    @(negedge clk);
    fl = k_flush || (k_rand && k_rflush && ($urandom % 64) == 0);
    flush = fl;
    if (k_rand) begin
      disp_valid     = ($urandom % 4) != 0;
      disp_ops_ready = ($urandom % 4) != 0;
      issue_ready    = ($urandom % 5) != 0;
    end else begin
      disp_valid = k_disp; disp_ops_ready = k_ops; issue_ready = k_iss;
    end
    disp_dest = 3'($urandom);
    disp_opnd = DW'($urandom);
    cmpl_valid = 0; cmpl_tag = '0; cmpl_value = '0; creal = 0; ctag = 0;
    if (k_bogus >= 0) begin
      cmpl_valid = 1; cmpl_tag = 3'(k_bogus); cmpl_value = DW'($urandom);
    end else if (!fl && k_cmp && (!k_rand || ($urandom % 10) < 7)) begin
      int st;
      st = $urandom % NE;
      for (int j = 0; j < NE; j++) begin
        int t;
        t = (st + j) % NE;
        if (!creal && if_v[t] && if_dly[t] == 0 && !(k_hold && if_seq[t] == m_head)) begin
          creal = 1; ctag = t;
        end
      end
      if (creal) begin
        cmpl_valid = 1; cmpl_tag = 3'(ctag);
        cmpl_value = res_fn(m_opnd[if_seq[ctag] % 32], m_dest[if_seq[ctag] % 32]);
      end
    end
    #1;
    // Expected outputs from the model state before this edge
    exp_dr = (m_ent != '1) && (m_tail - m_head < NR) && !fl;
    rq = (m_ent == '1) ? "R6" : (m_tail - m_head >= NR) ? "R7" : fl ? "R9" : "R1";
    chk(rq, disp_ready, exp_dr);
    exp_iv = (m_iss != m_tail) && !fl;
    chk(fl ? "R9" : "R3", issue_valid, exp_iv);
    if (exp_iv && issue_valid) begin
      chk("R2", issue_tag, m_tag[m_iss % 32]);
      chk("R3", issue_opnd, m_opnd[m_iss % 32]);
    end
    exp_cv = (m_head != m_tail) && m_done[m_head % 32] && !fl;
    chk(fl ? "R9" : "R8", commit_valid, exp_cv);
    if (exp_cv && commit_valid) begin
      chk("R8", commit_dest, m_dest[m_head % 32]);
      chk("R8", commit_value, m_val[m_head % 32]);
    end
    // Model update for the coming edge
    if (fl) begin
      for (int s = m_head; s < m_tail; s++) lg_kill[m_lg[s % 32]] = 1;
      m_tail = m_head; m_iss = m_head; m_ent = '0;
      for (int t = 0; t < NE; t++) if_v[t] = 0;
    end else begin
      at = first_free(m_ent);
      for (int t = 0; t < NE; t++) if (if_v[t] && if_dly[t] > 0) if_dly[t]--;
      if (exp_cv) begin
        arch[m_dest[m_head % 32]] = m_val[m_head % 32];
        m_done[m_head % 32] = 0;
        m_head++;
      end
      if (exp_iv && issue_ready) begin
        if_v[m_tag[m_iss % 32]] = 1;
        if_seq[m_tag[m_iss % 32]] = m_iss;
        if_dly[m_tag[m_iss % 32]] = $urandom % 5;
        m_iss++;
      end
      if (creal) begin
        m_ent[ctag] = 0; if_v[ctag] = 0;
        m_done[if_seq[ctag] % 32] = 1;
        m_val[if_seq[ctag] % 32] = cmpl_value;
      end
      if (disp_valid && disp_ops_ready && exp_dr) begin
        m_dest[m_tail % 32] = disp_dest;
        m_opnd[m_tail % 32] = disp_opnd;
        m_done[m_tail % 32] = 0;
        m_tag[m_tail % 32]  = 3'(at);
        m_lg[m_tail % 32]   = lg_n;
        m_ent[at] = 1;
        lg_dest[lg_n] = disp_dest; lg_opnd[lg_n] = disp_opnd; lg_kill[lg_n] = 0;
        lg_n++;
        m_tail++;
      end
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nmis);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    ncmp++; nmis++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_run();
  end

  initial begin
    logic [DW-1:0] refr [NA];
    void'($urandom(32'h5eed_0042));
    for (int r = 0; r < NA; r++) begin arch[r] = '0; refr[r] = '0; end
    for (int t = 0; t < NE; t++) if_v[t] = 0;
    for (int s = 0; s < 32; s++) m_done[s] = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R1 reset", disp_ready, 1);
    chk("R3 reset", issue_valid, 0);
    chk("R8 reset", commit_valid, 0);

    // R1: unresolved operands never allocate or issue
    k_disp = 1; k_ops = 0; k_iss = 1; k_cmp = 1;
    run(4);
    chk("R1 unready dropped", issue_valid, 0);

    // R6: stall issue until all entries are taken
    k_ops = 1; k_iss = 0;
    run(11);
    chk("R6 entries full", disp_ready, 0);

    // R5: completion to an unissued entry is ignored
    k_disp = 0; k_bogus = 0;
    run(1);
    k_bogus = -1;
    run(1);
    chk("R5 stray completion", commit_valid, 0);

    // R4: younger completions free entries while the oldest holds retirement
    k_iss = 1; k_hold = 1;
    run(25);
    chk("R4 early release", disp_ready, 1);
    chk("R4 nothing retired", commit_valid, 0);

    // R7: ring fills while entries remain free
    k_disp = 1;
    run(40);
    chk("R7 ring full", disp_ready, 0);

    // R8: release the oldest, retire in order
    k_disp = 0; k_hold = 0;
    run(40);
    chk("R8 drained", commit_valid, 0);

    // R9: flush during a busy stream
    k_disp = 1; k_iss = 1;
    run(6);
    k_flush = 1;
    run(1);
    k_flush = 0; k_disp = 0;
    run(1);
    chk("R9 after flush issue", issue_valid, 0);
    chk("R9 after flush commit", commit_valid, 0);
    chk("R9 after flush ready", disp_ready, 1);

    // Random stream with occasional flushes
    k_rand = 1; k_rflush = 1;
    run(5000);
    k_rand = 0; k_rflush = 0; k_disp = 0; k_iss = 1; k_cmp = 1;
    run(100);
    chk("R10 drained", m_tail - m_head, 0);

    // R10: sequential replay of surviving instructions
    for (int i = 0; i < lg_n; i++)
      if (!lg_kill[i]) refr[lg_dest[i]] = res_fn(lg_opnd[i], lg_dest[i]);
    for (int r = 0; r < NA; r++) chk("R10 arch reg", arch[r], refr[r]);
    finish_run();
  end

endmodule